// File: doc/BRIEF.md
# Staged Watchdog Escalation Controller

This block turns expiry pulses from a bank of free-running source timers into a ladder of escalating alarms. Software picks one source timer, sets how many of its pulses make up one watchdog period, and chooses which alarm outputs may fire. Once started, each completed period moves the controller one stage up. The first stage raises a local interrupt for servicing. Later stages raise the fast interrupt, the remote interrupt and the debug reset request. The fifth stage raises the power-on reset request.

Software services the watchdog by stopping it and starting it again. This returns the stage and the partial period count to zero. Every start or stop command must be preceded by a write of a key value, and the key is spent by the next command write. The configuration freezes once its local-interrupt enable is set, and only a reset releases it.

The register port is a plain single-cycle write strobe with a combinational read path. There is no streaming data and no back-pressure. The timers and the reset circuitry are outside the block.

Top module: `wdog_stager`

## Requirements
- R1: After reset, all alarm outputs and `stage_o` are 0 and the configuration register reads 0.
- R2: Offset 0x00 holds the configuration: bits 3:0 select the source, bits 11:4 set the period, bit 12 enables the local interrupt, bit 13 the fast interrupt, bit 14 the remote interrupt, bit 15 the debug reset and bit 16 the power-on reset. Bits 31:17 read as 0.
- R3: While configuration bit 12 is 1, writes to offset 0x00 are ignored until the next reset.
- R4: Writing 0x0000C45A to offset 0x0C arms the key. Writing any other value there disarms it. Any write to offset 0x08 consumes the key, whatever its data.
- R5: A write to offset 0x08 while the key is armed acts as a command. Bit 1 stops the watchdog and takes priority over bit 0, which starts it. A write without the armed key has no effect.
- R6: Reads of offsets 0x08 and 0x0C return 0.
- R7: While running, only pulses on `src_tick[sel]` are counted. Pulses on other inputs, and all pulses while stopped, are ignored.
- R8: One expiration occurs after `period` counted pulses. A period of 0 behaves as 1.
- R9: Each expiration raises `stage_o` by one, up to a ceiling of 5, visible the cycle after the completing pulse.
- R10: The outputs are levels. `irq_local` is high when the stage is at least 1 and bit 12 is set. `fiq_local` is high when the stage is at least 2 and bit 13 is set. `irq_remote` is high when the stage is at least 2 and bit 14 is set. `dbg_rst_req` is high when the stage is at least 4 and bit 15 is set. `por_rst_req` is high when the stage is 5 and bit 16 is set.
- R11: A stop clears the stage, the partial pulse count and all outputs. A later start therefore needs a full period before the first expiration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_tick | input | 16 | One-cycle expiry pulses from the source timers |
| stage_o | output | 3 | Current expiration stage, 0 to 5 |
| irq_local | output | 1 | Local interrupt |
| fiq_local | output | 1 | Local fast interrupt |
| irq_remote | output | 1 | Remote interrupt |
| dbg_rst_req | output | 1 | Debug reset request |
| por_rst_req | output | 1 | Power-on reset request |

## Verification
The bench targets the key handling in four ways: a command with no key, a key spent by an empty command, a key cancelled by a wrong value, and a command carrying both start and stop. A design that left the key armed, or that let start win, would move the stage where the checks expect it to stay. It writes zeros over a locked configuration; a broken lock would drop the local interrupt and switch the source. It also stops the watchdog halfway through a period and restarts it, which catches a partial count left over after a stop. The stage is driven past five, and the bench confirms that period zero expires on every pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 4;
  localparam int PER_W  = 8;
  localparam int STG_W  = 3;
  localparam int LAST_STAGE = 5;

  localparam logic [ADDR_W-1:0] OFF_CFG = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CMD = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_KEY = 8'h0C;
  localparam logic [DATA_W-1:0] KEY_VAL = 32'h0000_C45A;

  // Field order is fixed by the bit layout software writes.
  typedef struct packed {
    logic             en_por;
    logic             en_dbg;
    logic             en_rint;
    logic             en_fiq;
    logic             en_lint;
    logic [PER_W-1:0] period;
    logic [SEL_W-1:0] src;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg_q,
  output logic              key_armed,
  output logic              start_p,
  output logic              stop_p,
  output logic [DATA_W-1:0] rdata
);
  logic cmd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      key_armed <= 1'b0;
    end else if (wr) begin
      case (addr)
        OFF_CFG: if (!cfg_q.en_lint) cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
        OFF_KEY: key_armed <= (wdata == KEY_VAL);
        OFF_CMD: key_armed <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd_hit = wr && (addr == OFF_CMD) && key_armed;
    stop_p  = cmd_hit && wdata[1];
    start_p = cmd_hit && wdata[0] && !wdata[1];
    rdata   = (addr == OFF_CFG) ? DATA_W'(cfg_q) : '0;
  end
endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
  parameter int NUM_SRC = 16,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0] ticks,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);
  localparam int SRC_SPACE = 1 << SEL_W;

  logic [SRC_SPACE-1:0] padded;

  generate
    if (NUM_SRC < SRC_SPACE) begin : g_pad
      assign padded = {{(SRC_SPACE-NUM_SRC){1'b0}}, ticks};
    end else begin : g_full
      assign padded = ticks;
    end
  endgenerate

  assign hit = padded[sel];
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
  parameter int PER_W      = 8,
  parameter int STG_W      = 3,
  parameter int LAST_STAGE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic             hit,
  input  logic [PER_W-1:0] period,
  output logic [STG_W-1:0] stage_q
);
  localparam logic [STG_W-1:0] TOP = STG_W'(LAST_STAGE);

  logic             running;
  logic [PER_W-1:0] pcnt;
  logic [PER_W-1:0] eff;
  logic [PER_W:0]   nxt;
  logic             expire;

  always_comb begin
    eff    = (period == '0) ? PER_W'(1) : period;
    nxt    = {1'b0, pcnt} + 1'b1;
    expire = nxt >= {1'b0, eff};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pcnt    <= '0;
      stage_q <= '0;
    end else if (stop_p) begin
      running <= 1'b0;
      pcnt    <= '0;
      stage_q <= '0;
    end else begin
      if (start_p) running <= 1'b1;
      if (running && hit) begin
        if (expire) begin
          pcnt <= '0;
          if (stage_q != TOP) stage_q <= stage_q + 1'b1;
        end else begin
          pcnt <= nxt[PER_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/wdog_stager.sv
module wdog_stager
  import wdog_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [2:0]         stage_o,
  output logic               irq_local,
  output logic               fiq_local,
  output logic               irq_remote,
  output logic               dbg_rst_req,
  output logic               por_rst_req
);
  cfg_t cfg_q;
  logic key_armed;
  logic start_p;
  logic stop_p;
  logic hit;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cfg_q(cfg_q), .key_armed(key_armed), .start_p(start_p), .stop_p(stop_p),
    .rdata(reg_rdata)
  );

  wdog_tick_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .ticks(src_tick), .sel(cfg_q.src), .hit(hit)
  );

  wdog_escalate #(.PER_W(PER_W), .STG_W(STG_W), .LAST_STAGE(LAST_STAGE)) u_esc (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p), .hit(hit),
    .period(cfg_q.period), .stage_q(stage_o)
  );

  always_comb begin
    irq_local   = cfg_q.en_lint && (stage_o >= 3'd1);
    fiq_local   = cfg_q.en_fiq  && (stage_o >= 3'd2);
    irq_remote  = cfg_q.en_rint && (stage_o >= 3'd2);
    dbg_rst_req = cfg_q.en_dbg  && (stage_o >= 3'd4);
    por_rst_req = cfg_q.en_por  && (stage_o == 3'd5);
  end
endmodule

// File: rtl/wdog_stager_chk.sv
module wdog_stager_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [2:0]  stage_o,
  input logic        key_armed,
  input logic [16:0] cfg_bits
);
  AST_STAGE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    stage_o <= 3'd5); // R9

  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_o > $past(stage_o)) |-> (stage_o == $past(stage_o) + 3'd1)); // R9

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_bits[12]) |-> $stable(cfg_bits)); // R3

  AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == 8'h08) |-> !key_armed); // R4

  AST_CLEAR_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_o == 3'd0 && $past(stage_o) != 3'd0) |->
      $past(reg_wr && reg_addr == 8'h08 && key_armed && reg_wdata[1])); // R5
endmodule

bind wdog_stager wdog_stager_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .stage_o(stage_o), .key_armed(key_armed),
  .cfg_bits(cfg_q)
);

// File: tb/tb_wdog_stager.sv
module tb_wdog_stager;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] src_tick = '0;
  logic [2:0]  stage_o;
  logic irq_local, fiq_local, irq_remote, dbg_rst_req, por_rst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  wdog_stager dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick),
    .stage_o(stage_o), .irq_local(irq_local), .fiq_local(fiq_local),
    .irq_remote(irq_remote), .dbg_rst_req(dbg_rst_req), .por_rst_req(por_rst_req)
  );

  // {req[53:50], kind[49:48] (0 write, 1 tick), addr[47:40], data[39:8],
  //  stage[7:5], outs[4:0] = {por,dbg,remote,fiq,local}}
  localparam int NV = 35;
  localparam logic [53:0] VEC [0:NV-1] = '{
    {4'd2,  2'd0, 8'h00, 32'h0001E023, 3'd0, 5'b00000}, // R2 src3 period2
    {4'd5,  2'd0, 8'h08, 32'h00000001, 3'd0, 5'b00000}, // R5 no key
    {4'd7,  2'd1, 8'h00, 32'd3,        3'd0, 5'b00000}, // R7 stopped
    {4'd4,  2'd0, 8'h0C, 32'h0000C45A, 3'd0, 5'b00000}, // R4
    {4'd5,  2'd0, 8'h08, 32'h00000001, 3'd0, 5'b00000}, // R5 start
    {4'd7,  2'd1, 8'h00, 32'd5,        3'd0, 5'b00000}, // R7 other source
    {4'd8,  2'd1, 8'h00, 32'd3,        3'd0, 5'b00000}, // R8
    {4'd10, 2'd1, 8'h00, 32'd3,        3'd1, 5'b00000}, // R10 local off
    {4'd8,  2'd1, 8'h00, 32'd3,        3'd1, 5'b00000}, // R8
    {4'd10, 2'd1, 8'h00, 32'd3,        3'd2, 5'b00110}, // R10
    {4'd9,  2'd1, 8'h00, 32'd3,        3'd2, 5'b00110}, // R9
    {4'd9,  2'd1, 8'h00, 32'd3,        3'd3, 5'b00110}, // R9
    {4'd9,  2'd1, 8'h00, 32'd3,        3'd3, 5'b00110}, // R9
    {4'd10, 2'd1, 8'h00, 32'd3,        3'd4, 5'b01110}, // R10
    {4'd9,  2'd1, 8'h00, 32'd3,        3'd4, 5'b01110}, // R9
    {4'd10, 2'd1, 8'h00, 32'd3,        3'd5, 5'b11110}, // R10
    {4'd9,  2'd1, 8'h00, 32'd3,        3'd5, 5'b11110}, // R9
    {4'd9,  2'd1, 8'h00, 32'd3,        3'd5, 5'b11110}, // R9 ceiling
    {4'd4,  2'd0, 8'h0C, 32'h0000C45A, 3'd5, 5'b11110}, // R4
    {4'd11, 2'd0, 8'h08, 32'h00000002, 3'd0, 5'b00000}, // R11 stop
    {4'd8,  2'd0, 8'h00, 32'h00011003, 3'd0, 5'b00000}, // R8 period0, locks
    {4'd4,  2'd0, 8'h0C, 32'h0000C45A, 3'd0, 5'b00000}, // R4
    {4'd5,  2'd0, 8'h08, 32'h00000001, 3'd0, 5'b00000}, // R5
    {4'd8,  2'd1, 8'h00, 32'd3,        3'd1, 5'b00001}, // R8 zero as one
    {4'd3,  2'd0, 8'h00, 32'h00000000, 3'd1, 5'b00001}, // R3 locked
    {4'd8,  2'd1, 8'h00, 32'd3,        3'd2, 5'b00001}, // R8
    {4'd4,  2'd0, 8'h0C, 32'h0000C45A, 3'd2, 5'b00001}, // R4
    {4'd4,  2'd0, 8'h08, 32'h00000000, 3'd2, 5'b00001}, // R4 spent
    {4'd4,  2'd0, 8'h08, 32'h00000002, 3'd2, 5'b00001}, // R4 ignored
    {4'd4,  2'd0, 8'h0C, 32'h0000C45A, 3'd2, 5'b00001}, // R4
    {4'd4,  2'd0, 8'h0C, 32'h00001234, 3'd2, 5'b00001}, // R4 disarm
    {4'd4,  2'd0, 8'h08, 32'h00000002, 3'd2, 5'b00001}, // R4 ignored
    {4'd4,  2'd0, 8'h0C, 32'h0000C45A, 3'd2, 5'b00001}, // R4
    {4'd5,  2'd0, 8'h08, 32'h00000003, 3'd0, 5'b00000}, // R5 stop wins
    {4'd5,  2'd1, 8'h00, 32'd3,        3'd0, 5'b00000}  // R5 stayed stopped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic tick(input int idx);
    @(negedge clk);
    src_tick = 16'(1) << idx;
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = '0;
  endtask

  function automatic logic [4:0] outs();
    return {por_rst_req, dbg_rst_req, irq_remote, fiq_local, irq_local};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    do_reset();
    chk("R1 stage", 32'(stage_o), 32'd0);
    chk("R1 outs", 32'(outs()), 32'd0);
    rd(8'h00, d);
    chk("R1 cfg", d, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VEC[i];
      if (v[49:48] == 2'd0) wr(v[47:40], v[39:8]);
      else tick(int'(v[11:8]));
      chk($sformatf("R%0d vec%0d stage", v[53:50], i), 32'(stage_o), 32'(v[7:5]));
      chk($sformatf("R%0d vec%0d outs", v[53:50], i), 32'(outs()), 32'(v[4:0]));
    end

    rd(8'h00, d);
    chk("R3 locked cfg readback", d, 32'h00011003);
    wr(8'h0C, 32'h0000C45A);
    rd(8'h0C, d);
    chk("R6 key read", d, 32'd0);
    rd(8'h08, d);
    chk("R6 cmd read", d, 32'd0);

    do_reset();
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, d);
    chk("R2 upper bits zero", d, 32'h0001FFFF);
    wr(8'h00, 32'h0);
    rd(8'h00, d);
    chk("R3 write ignored", d, 32'h0001FFFF);

    // R11: partial count discarded by stop
    do_reset();
    wr(8'h00, 32'h00001030);
    wr(8'h0C, 32'h0000C45A);
    wr(8'h08, 32'h1);
    tick(0); tick(0);
    wr(8'h0C, 32'h0000C45A);
    wr(8'h08, 32'h2);
    wr(8'h0C, 32'h0000C45A);
    wr(8'h08, 32'h1);
    tick(0); tick(0);
    chk("R11 fresh count stage", 32'(stage_o), 32'd0);
    tick(0);
    chk("R11 full period stage", 32'(stage_o), 32'd1);
    chk("R11 local irq", 32'(outs()), 32'd1);

    finish_up();
  end
endmodule